// File: doc/BRIEF.md
# DMA Address Output and Upper-Byte Strobe Sequencer

This block drives the address and bus-command outputs of a DMA engine for one transfer at a time. A one-cycle start pulse supplies a 16-bit transfer address, a transfer kind and a block-mode flag. The block then takes the bus and steps through a short state sequence. The low address byte goes out on dedicated address pins. The high address byte is driven onto the shared data bus, where an external transparent latch captures it under an active-high upper-byte strobe. An active-high address-enable output gates that latch onto the system bus. The block also sequences the memory and I/O read/write strobes for the transfer and holds them asserted while a slow target keeps the ready input low.

A transfer takes these states in order: an optional upper-byte strobe state, a read state, a write state and a closing state. The read state asserts the read strobe. The write state asserts both strobes and samples ready; it repeats as wait states while ready is low. The closing state releases both strobes. Back-to-back block-mode transfers form one service. Inside a service, the strobe state is skipped whenever the upper address byte matches the byte latched by the previous transfer, which saves one cycle per transfer. Every output is driven only while the block owns the bus and is released otherwise.

Top module: `dma_addr_seq`

## Requirements
- R1: During and after reset, with no transfer started: aen_o, adstb_o, xfer_done_o and all three output-enable pins are low, and the four active-low strobes are high.
- R2: A start with block_i low, or the first start of a service, spends exactly one cycle with adstb_o high. That cycle is the one right after the start edge, and db_o carries addr_i[15:8] during it.
- R3: A start with block_i high, accepted in the first idle cycle after a block-mode transfer, skips the strobe state if addr_i[15:8] equals that transfer's upper byte. The transfer is then one cycle shorter and adstb_o never rises. If the upper byte differs, the strobe state is issued.
- R4: A service ends at any idle cycle without a start, or at any transfer started with block_i low. The next block-mode transfer then issues the strobe state even if the upper byte is the same.
- R5: aen_o, addr_oe_o, db_oe_o and ctl_oe_o are high in every cycle of a transfer and low otherwise. A transfer with a strobe state and no wait states lasts 4 cycles; one that skips the strobe state lasts 3.
- R6: xfer_type_i = 2'b10 is a DMA read. memr_n_o is low in the read state, in the write state and in every wait state. iow_n_o is low in the write state and every wait state. memw_n_o and ior_n_o stay high.
- R7: xfer_type_i = 2'b01 is a DMA write. ior_n_o is low in the read state, in the write state and in every wait state. memw_n_o is low in the write state and every wait state. memr_n_o and iow_n_o stay high.
- R8: Each cycle in which ready_i is low at the write-state sample edge adds one wait state. During a wait state both strobes stay asserted.
- R9: xfer_type_i = 2'b00 (verify) and 2'b11 (treated as verify) assert no strobe and ignore ready_i. Such a transfer never takes a wait state.
- R10: addr_lo_o equals addr_i[7:0] of the accepted start throughout the transfer.
- R11: xfer_done_o is high for exactly one cycle, which is the last cycle of the transfer. The cycle after it is idle.
- R12: A start pulse that arrives while a transfer is in progress is ignored: it neither starts a transfer nor changes the outputs of the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle transfer start, accepted only when idle |
| addr_i | input | 16 | Transfer address, sampled with start_i |
| xfer_type_i | input | 2 | 00 verify, 01 DMA write, 10 DMA read, 11 verify |
| block_i | input | 1 | Block-mode flag, sampled with start_i |
| ready_i | input | 1 | Target ready, sampled in the write state |
| addr_lo_o | output | 8 | Low address byte |
| addr_oe_o | output | 1 | Enable for the address pins |
| db_o | output | 8 | Upper address byte driven on the data bus |
| db_oe_o | output | 1 | Enable for the data-bus drivers |
| adstb_o | output | 1 | Upper-byte latch strobe, active high |
| aen_o | output | 1 | Address enable, active high |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| ctl_oe_o | output | 1 | Enable for the four strobe pins |
| xfer_done_o | output | 1 | Last cycle of a transfer |

## Verification
Take the start edge as edge k. With a strobe state, adstb_o is due in the cycle after edge k. The read strobe follows one edge later and the write strobe one edge after that. The first ready sample falls at edge k+3, each low sample adds one cycle, and xfer_done_o is due after edge k+3+n. Without a strobe state, every step comes one edge earlier. The driver computes these edges, drives ready_i low only at the sample edges it wants to stall, and pushes the cycle counts it expects for each output. The monitor samples on the falling edge, counts every output over the transfer and compares those counts when xfer_done_o appears, so an output that is one cycle early or late changes a count.

// File: rtl/dma_aseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the DMA address sequencer.
// Assumes: the transfer kind is a 2-bit code, and code 3 behaves like verify.
package dma_aseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_STB  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_END  = 3'd4
    } aseq_state_e;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'b00,
        XF_WRITE  = 2'b01,
        XF_READ   = 2'b10,
        XF_RSVD   = 2'b11
    } aseq_xfer_e;

endpackage

// File: rtl/aseq_hi_track.sv
`timescale 1ns/1ps
// Remembers the upper address byte latched by the last transfer and
// decides whether the next one needs the upper-byte strobe state.
// Assumes: accept_i is high only in the cycle a start is taken, and
// gap_i marks an idle cycle without a start (the end of a service).
module aseq_hi_track #(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            gap_i,
    input  logic            blk_i,
    input  logic [HI_W-1:0] hi_i,
    output logic            need_stb_o
);

    logic [HI_W-1:0] hi_q;
    logic            valid_q;

    // Capture the byte at each accepted start; a gap ends the service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            valid_q <= 1'b0;
        end else if (accept_i) begin
            hi_q    <= hi_i;
            valid_q <= blk_i;
        end else if (gap_i) begin
            valid_q <= 1'b0;
        end
    end

    // Skip the strobe only inside a block service on a matching byte.
    always_comb begin
        need_stb_o = !(blk_i && valid_q && (hi_i == hi_q));
    end

endmodule

// File: rtl/aseq_fsm.sv
`timescale 1ns/1ps
// Transfer state sequencer: idle, optional strobe, read, write (with wait
// states), and a closing state. Starts are taken only when idle.
// Assumes: verify_i reflects the kind of the transfer in progress.
module aseq_fsm
    import dma_aseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        need_stb_i,
    input  logic        ready_i,
    input  logic        verify_i,
    output aseq_state_e state_o,
    output logic        accept_o,
    output logic        gap_o
);

    aseq_state_e state_q;
    aseq_state_e state_d;

    // Next-state choice for each state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = need_stb_i ? ST_STB : ST_RD;
            ST_STB:  state_d = ST_RD;
            ST_RD:   state_d = ST_WR;
            ST_WR:   if (verify_i || ready_i) state_d = ST_END;
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Start acceptance and service-gap flags for the byte tracker.
    always_comb begin
        accept_o = (state_q == ST_IDLE) && start_i;
        gap_o    = (state_q == ST_IDLE) && !start_i;
        state_o  = state_q;
    end

endmodule

// File: rtl/aseq_strobe_dec.sv
`timescale 1ns/1ps
// Decodes the sequencer state and transfer kind into bus strobes.
// Assumes: state comes straight from a register, so outputs are glitch-free.
module aseq_strobe_dec
    import dma_aseq_pkg::*;
(
    input  aseq_state_e state_i,
    input  aseq_xfer_e  xtype_i,
    output logic        adstb_o,
    output logic        aen_o,
    output logic        done_o,
    output logic        memr_n_o,
    output logic        memw_n_o,
    output logic        ior_n_o,
    output logic        iow_n_o
);

    logic rd_phase;
    logic wr_phase;
    logic is_rd;
    logic is_wr;

    // Phase and kind decode, then active-low strobe mapping.
    always_comb begin
        rd_phase = (state_i == ST_RD) || (state_i == ST_WR);
        wr_phase = (state_i == ST_WR);
        is_rd    = (xtype_i == XF_READ);
        is_wr    = (xtype_i == XF_WRITE);
        adstb_o  = (state_i == ST_STB);
        aen_o    = (state_i != ST_IDLE);
        done_o   = (state_i == ST_END);
        memr_n_o = !(rd_phase && is_rd);
        iow_n_o  = !(wr_phase && is_rd);
        ior_n_o  = !(rd_phase && is_wr);
        memw_n_o = !(wr_phase && is_wr);
    end

endmodule

// File: rtl/dma_addr_seq.sv
`timescale 1ns/1ps
// Top of the DMA address output sequencer. Latches the transfer at an
// accepted start and drives the address, the upper-byte strobe, the address
// enable and the bus strobes, with enables high only while the bus is owned.
// Assumes: ready_i is synchronous to clk.
module dma_addr_seq
    import dma_aseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LO_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [1:0]             xfer_type_i,
    input  logic                   block_i,
    input  logic                   ready_i,
    output logic [LO_W-1:0]        addr_lo_o,
    output logic                   addr_oe_o,
    output logic [ADDR_W-LO_W-1:0] db_o,
    output logic                   db_oe_o,
    output logic                   adstb_o,
    output logic                   aen_o,
    output logic                   memr_n_o,
    output logic                   memw_n_o,
    output logic                   ior_n_o,
    output logic                   iow_n_o,
    output logic                   ctl_oe_o,
    output logic                   xfer_done_o
);

    localparam int HI_W = ADDR_W - LO_W;

    logic [ADDR_W-1:0] addr_q;
    aseq_xfer_e        xtype_q;
    aseq_state_e       state;
    logic              accept;
    logic              gap;
    logic              need_stb;
    logic              verify;
    logic              aen;

    // Hold the address and transfer kind for the length of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            xtype_q <= XF_VERIFY;
        end else if (accept) begin
            addr_q  <= addr_i;
            xtype_q <= aseq_xfer_e'(xfer_type_i);
        end
    end

    // Verify and the spare code both run without strobes or waits.
    always_comb begin
        verify = (xtype_q == XF_VERIFY) || (xtype_q == XF_RSVD);
    end

    aseq_hi_track #(.HI_W(HI_W)) u_hi (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .gap_i      (gap),
        .blk_i      (block_i),
        .hi_i       (addr_i[ADDR_W-1:LO_W]),
        .need_stb_o (need_stb)
    );

    aseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .need_stb_i (need_stb),
        .ready_i    (ready_i),
        .verify_i   (verify),
        .state_o    (state),
        .accept_o   (accept),
        .gap_o      (gap)
    );

    aseq_strobe_dec u_dec (
        .state_i  (state),
        .xtype_i  (xtype_q),
        .adstb_o  (adstb_o),
        .aen_o    (aen),
        .done_o   (xfer_done_o),
        .memr_n_o (memr_n_o),
        .memw_n_o (memw_n_o),
        .ior_n_o  (ior_n_o),
        .iow_n_o  (iow_n_o)
    );

    // Address and enable outputs, driven only while the bus is owned.
    always_comb begin
        aen_o     = aen;
        addr_oe_o = aen;
        db_oe_o   = aen;
        ctl_oe_o  = aen;
        addr_lo_o = addr_q[LO_W-1:0];
        db_o      = addr_q[ADDR_W-1:LO_W];
    end

endmodule

// File: rtl/aseq_chk.sv
`timescale 1ns/1ps
// Protocol checker for dma_addr_seq, attached by bind below.
// Assumes: rst_n is low at the first clock edge.
module aseq_chk #(
    parameter int LO_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready_i,
    input logic            aen_o,
    input logic            adstb_o,
    input logic            memr_n_o,
    input logic            memw_n_o,
    input logic            ior_n_o,
    input logic            iow_n_o,
    input logic            xfer_done_o,
    input logic [LO_W-1:0] addr_lo_o
);

    // R2: the upper-byte strobe lasts a single cycle.
    p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adstb_o |=> !adstb_o);

    // R5: nothing is strobed while the bus is not owned.
    p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !aen_o |-> (memr_n_o && memw_n_o && ior_n_o && iow_n_o && !adstb_o));

    // R6: a DMA read never asserts both memory strobes.
    p_mem_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!memr_n_o && !memw_n_o));

    // R7: a DMA write never asserts both I/O strobes.
    p_io_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ior_n_o && !iow_n_o));

    // R8: ready low in the write state holds the read-transfer strobes.
    p_wait_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_i && !memr_n_o && !iow_n_o) |=> (!memr_n_o && !iow_n_o));

    // R8: the same holds for write transfers.
    p_wait_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_i && !ior_n_o && !memw_n_o) |=> (!ior_n_o && !memw_n_o));

    // R10: the low address byte does not move within a transfer.
    p_lo_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (aen_o && !adstb_o && $past(aen_o)) |-> $stable(addr_lo_o));

    // R11: done is a single-cycle pulse followed by an idle cycle.
    p_done_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |=> (!xfer_done_o && !aen_o));

endmodule

bind dma_addr_seq aseq_chk #(.LO_W(LO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready_i),
    .aen_o       (aen_o),
    .adstb_o     (adstb_o),
    .memr_n_o    (memr_n_o),
    .memw_n_o    (memw_n_o),
    .ior_n_o     (ior_n_o),
    .iow_n_o     (iow_n_o),
    .xfer_done_o (xfer_done_o),
    .addr_lo_o   (addr_lo_o)
);

// File: tb/sim_dma_addr_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes per-transfer expected counts, and the
// monitor accumulates the outputs and compares them at each done pulse.
module sim_dma_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [1:0]  xfer_type_i = 2'b00;
    logic        block_i = 1'b0;
    logic        ready_i = 1'b1;
    logic [7:0]  addr_lo_o;
    logic        addr_oe_o;
    logic [7:0]  db_o;
    logic        db_oe_o;
    logic        adstb_o;
    logic        aen_o;
    logic        memr_n_o;
    logic        memw_n_o;
    logic        ior_n_o;
    logic        iow_n_o;
    logic        ctl_oe_o;
    logic        xfer_done_o;

    always #2.5 clk = ~clk;

    dma_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .xfer_type_i(xfer_type_i), .block_i(block_i), .ready_i(ready_i),
        .addr_lo_o(addr_lo_o), .addr_oe_o(addr_oe_o), .db_o(db_o),
        .db_oe_o(db_oe_o), .adstb_o(adstb_o), .aen_o(aen_o),
        .memr_n_o(memr_n_o), .memw_n_o(memw_n_o), .ior_n_o(ior_n_o),
        .iow_n_o(iow_n_o), .ctl_oe_o(ctl_oe_o), .xfer_done_o(xfer_done_o)
    );

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] stb;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] memr;
        logic [7:0] memw;
        logic [7:0] ior;
        logic [7:0] iow;
    } rec_t;

    rec_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   dones  = 0;
    logic mdl_valid = 1'b0;
    logic [7:0] mdl_hi = '0;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: one transfer with n wait states; poke re-pulses start mid-transfer.
    task automatic xfer(input logic [15:0] a, input logic [1:0] t,
                        input logic blk, input int n, input bit poke);
        rec_t e;
        int   s;
        int   nn;
        bit   ver;
        ver = (t == 2'b00) || (t == 2'b11);
        nn  = ver ? 0 : n;
        s   = (blk && mdl_valid && a[15:8] == mdl_hi) ? 0 : 1;
        e.len  = 8'(3 + s + nn);
        e.stb  = 8'(s);
        e.hi   = s ? a[15:8] : 8'h00;
        e.lo   = a[7:0];
        e.memr = (t == 2'b10) ? 8'(2 + nn) : 8'd0;
        e.iow  = (t == 2'b10) ? 8'(1 + nn) : 8'd0;
        e.ior  = (t == 2'b01) ? 8'(2 + nn) : 8'd0;
        e.memw = (t == 2'b01) ? 8'(1 + nn) : 8'd0;
        exp_q.push_back(e);
        mdl_valid = blk;
        mdl_hi    = a[15:8];
        start_i = 1'b1; addr_i = a; xfer_type_i = t; block_i = blk; ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int ed = 1; ed <= 3 + s + nn; ed++) begin
            if (ver) ready_i = 1'b0;
            else     ready_i = !(ed >= 2 + s && ed < 2 + s + n);
            if (poke && ed == 1) begin
                start_i = 1'b1; addr_i = ~a; xfer_type_i = 2'b01; block_i = ~blk;
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
        end
        ready_i = 1'b1;
    endtask

    // One idle cycle without a start: ends a block service (R4).
    task automatic gap();
        mdl_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: accumulate per-transfer output counts, compare at done.
    int   m_len = 0, m_stb = 0, m_hi = 0, m_lo = -1;
    int   m_memr = 0, m_memw = 0, m_ior = 0, m_iow = 0;
    int   m_oe_bad = 0, m_lo_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((addr_oe_o != aen_o) || (db_oe_o != aen_o) || (ctl_oe_o != aen_o))
                m_oe_bad++;
            if (aen_o) begin
                m_len++;
                if (m_lo < 0) m_lo = int'(addr_lo_o);
                else if (m_lo != int'(addr_lo_o)) m_lo_bad++;
                if (adstb_o) begin m_stb++; m_hi = int'(db_o); end
                if (!memr_n_o) m_memr++;
                if (!memw_n_o) m_memw++;
                if (!ior_n_o)  m_ior++;
                if (!iow_n_o)  m_iow++;
            end else begin
                if (!memr_n_o || !memw_n_o || !ior_n_o || !iow_n_o || adstb_o) m_oe_bad++;
            end
            if (xfer_done_o) begin
                rec_t e;
                dones++;
                if (exp_q.size() == 0) begin
                    chk("R12 unexpected transfer", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R5 length", m_len, int'(e.len));
                    chk("R2/R3 strobe cycles", m_stb, int'(e.stb));
                    chk("R2 upper byte on db", m_hi, int'(e.hi));
                    chk("R10 low byte", m_lo, int'(e.lo));
                    chk("R10 low byte stable", m_lo_bad, 0);
                    chk("R6 memr cycles", m_memr, int'(e.memr));
                    chk("R6 iow cycles", m_iow, int'(e.iow));
                    chk("R7 ior cycles", m_ior, int'(e.ior));
                    chk("R7 memw cycles", m_memw, int'(e.memw));
                    chk("R5 enables follow aen", m_oe_bad, 0);
                end
                m_len = 0; m_stb = 0; m_hi = 0; m_lo = -1;
                m_memr = 0; m_memw = 0; m_ior = 0; m_iow = 0;
                m_oe_bad = 0; m_lo_bad = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 aen", int'(aen_o), 0);
        chk("R1 adstb", int'(adstb_o), 0);
        chk("R1 done", int'(xfer_done_o), 0);
        chk("R1 enables", int'({addr_oe_o, db_oe_o, ctl_oe_o}), 0);
        chk("R1 strobes", int'({memr_n_o, memw_n_o, ior_n_o, iow_n_o}), 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(aen_o), 0);
        // R2, R6: non-block read, no waits
        xfer(16'h12A5, 2'b10, 1'b0, 0, 1'b0);
        gap();
        // R7, R8: write with two wait states
        xfer(16'h7F01, 2'b01, 1'b0, 2, 1'b0);
        // R8: read with three wait states
        xfer(16'h7F02, 2'b10, 1'b0, 3, 1'b0);
        // R9: verify with ready held low, both verify codes
        xfer(16'hC0DE, 2'b00, 1'b0, 4, 1'b0);
        xfer(16'hC0DF, 2'b11, 1'b0, 4, 1'b0);
        gap();
        // R3: block service, first strobes, then skips, then a byte change
        xfer(16'h3400, 2'b10, 1'b1, 0, 1'b0);
        xfer(16'h3401, 2'b10, 1'b1, 0, 1'b0);
        xfer(16'h3402, 2'b01, 1'b1, 1, 1'b0);
        xfer(16'h3500, 2'b10, 1'b1, 0, 1'b0);
        xfer(16'h3501, 2'b00, 1'b1, 0, 1'b0);
        // R4: a gap ends the service, so the same byte strobes again
        gap();
        xfer(16'h3502, 2'b10, 1'b1, 0, 1'b0);
        // R4: a non-block transfer ends the service
        xfer(16'h3503, 2'b10, 1'b0, 0, 1'b0);
        xfer(16'h3504, 2'b10, 1'b1, 0, 1'b0);
        gap();
        // R12: start pulses during a transfer are ignored
        xfer(16'h5A5A, 2'b10, 1'b0, 1, 1'b1);
        xfer(16'h5A5B, 2'b10, 1'b1, 0, 1'b1);
        repeat (4) @(negedge clk);
        // R11, R12: every pushed transfer finished, nothing extra
        chk("R12 pending expected", exp_q.size(), 0);
        chk("R11 done count", dones, 15);
        chk("R5 idle at end", int'(aen_o), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule